// File: doc/BRIEF.md
# Host DMA Transfer Engine

This block streams words between a host processor and a word-addressed external memory. Software sets a start address in a pointer register. It then sets an enable bit together with a direction bit in a control register. From then on the engine issues memory cycles one at a time, each at the address held in a private working counter, and steps that counter after every completed cycle. The transfer has no length: it runs until software clears the enable bit. A cycle already in flight at that moment still finishes.

On the host side there are three paths. A small register bus carries control, status and the pointer. A ready/valid word stream feeds the engine when it writes memory. A second ready/valid stream delivers words to the host when it reads memory. Both streams pass through one shared holding buffer, whose role follows the direction of the active transfer. On the memory side, a request is held with stable address and data until the memory acknowledges it. Any DRAM latency, refresh or arbitration shows up only as acknowledge delay.

Top module: `hostDmaEngine`

## Requirements
- R1: After reset the engine is idle: memReq is 0, the control register reads 0, the pointer reads 0, hostRdValid is 0 and hostWrReady is 0.
- R2: Register select 0 is control: bit 0 enable, bit 1 direction (1 = write memory, 0 = read memory), bit 2 busy (read-only), upper bits read 0. Register select 1 is the pointer, read back as written.
- R3: Writing enable from 0 to 1 while no cycle is in flight loads the working address from the pointer. The first cycle uses that address. The pointer itself changes only on a host write to it, and a pointer write during a transfer does not alter the addresses in use.
- R4: Every completed memory cycle (memReq and memAck high together) advances the working address by one, wrapping modulo 2^ADDR_W.
- R5: memReq, memAddr and memWe stay stable until memAck (and memWData too for a write). At most one cycle is outstanding, and memReq is low for at least one clock after each completion.
- R6: In read direction each word returned by memory goes to the host in order via hostRdValid/hostRdReady. No cycle is issued while the holding buffer holds BUF_DEPTH words.
- R7: In write direction host words are taken when hostWrValid and hostWrReady are both high, and are written to memory in order. hostWrReady is low when the buffer is full, and no cycle is issued while the buffer is empty.
- R8: While enable is 0 no new cycle is issued. A cycle in flight when enable clears still completes. Control writes made while that last cycle is still outstanding are ignored.
- R9: Busy is high while a cycle is outstanding, and between cycles while enable is still set once the first cycle has been issued. It is low before the first issue after a start, and once the last cycle has completed with enable clear.
- R10: The direction in force is captured at the start. Later direction writes change only the readable bit and do not affect the active transfer. The holding buffer is emptied at each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 pointer |
| regWData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Read data of the selected register |
| hostWrValid | input | 1 | Host offers a word for memory write |
| hostWrReady | output | 1 | Engine accepts a host word |
| hostWrData | input | DATA_W | Host word to be written |
| hostRdValid | output | 1 | A word read from memory is available |
| hostRdReady | input | 1 | Host takes the available word |
| hostRdData | output | DATA_W | Word read from memory |
| memReq | output | 1 | Memory cycle request |
| memWe | output | 1 | 1 = write cycle, 0 = read cycle |
| memAddr | output | ADDR_W | Word address of the cycle |
| memWData | output | DATA_W | Write data of the cycle |
| memAck | input | 1 | Memory completes the cycle |
| memRData | input | DATA_W | Read data, valid with memAck |

## Verification
The bench stalls the host reader until the buffer fills. A design that ignored occupancy would keep requesting and lose words. It clears enable while the memory holds a request unacknowledged and then tries to restart at once. A design that dropped the request, or accepted the restart, would show a missing completion or a working address reloaded mid-cycle. It moves the pointer and flips the direction bit during a live transfer. An engine that tracked the visible registers directly would jump addresses or reverse the data flow. A start at the top of the address space catches a counter that saturates or spills instead of wrapping to zero.

// File: rtl/hostDmaPkg.sv
package hostDmaPkg;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_DIR_BIT  = 1;
  localparam int CTRL_BUSY_BIT = 2;

  localparam logic REG_SEL_CTRL = 1'b0;
  localparam logic REG_SEL_PTR  = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic start;   // transfer begins: load working address, latch direction, flush buffer
    logic done;    // memory cycle completes this clock
  } engStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CYCLE = 1'b1
  } engState_t;

endpackage

// File: rtl/hostDmaCtrl.sv
module hostDmaCtrl
  import hostDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regAddr,
  input  logic [1:0] ctrlWData,
  input  logic       memAck,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  input  logic       workDir,
  output engStrobe_t strobe,
  output logic       ctrlEnable,
  output logic       ctrlDir,
  output logic       busy,
  output logic       memReq
);

  engState_t state;
  logic enableQ, dirQ, startedQ;
  logic inFlight, ctrlWrite, blockWrite, startGo, issueGo, doneGo;

  assign inFlight   = (state == ST_CYCLE);
  assign ctrlWrite  = regWr && (regAddr == REG_SEL_CTRL);
  // last cycle still draining after enable cleared: control writes are dropped
  assign blockWrite = ctrlWrite && !enableQ && inFlight;
  assign startGo    = ctrlWrite && ctrlWData[CTRL_EN_BIT] && !enableQ && !inFlight;
  assign issueGo    = !inFlight && enableQ && (workDir ? !fifoEmpty : !fifoFull);
  assign doneGo     = inFlight && memAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      dirQ     <= 1'b0;
      startedQ <= 1'b0;
      state    <= ST_IDLE;
    end else begin
      if (ctrlWrite && !blockWrite) begin
        enableQ <= ctrlWData[CTRL_EN_BIT];
        dirQ    <= ctrlWData[CTRL_DIR_BIT];
      end
      if (startGo)      startedQ <= 1'b0;
      else if (issueGo) startedQ <= 1'b1;
      if (issueGo)     state <= ST_CYCLE;
      else if (doneGo) state <= ST_IDLE;
    end
  end

  always_comb begin
    strobe.start = startGo;
    strobe.done  = doneGo;
  end

  assign ctrlEnable = enableQ;
  assign ctrlDir    = dirQ;
  assign busy       = inFlight || (enableQ && startedQ);
  assign memReq     = inFlight;

  // R5: a request is held until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
  // R5: turnaround gap after every completion
  a_r5_gap: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq);
  // R8: no new cycle once enable is low and nothing is outstanding
  a_r8_no_issue_off: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEnable && !memReq) |=> !memReq);
  // R9: busy covers every outstanding cycle
  a_r9_busy_covers: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

// File: rtl/hostDmaPath.sv
module hostDmaPath
  import hostDmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWData,
  input  engStrobe_t        strobe,
  input  logic              ctrlEnable,
  input  logic              ctrlDir,
  input  logic              busy,
  input  logic              hostWrValid,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRdReady,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] regRdData,
  output logic              hostWrReady,
  output logic              hostRdValid,
  output logic [DATA_W-1:0] hostRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              workDir
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptrReg, workAddr;
  logic              workDirQ;
  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic hostPush, hostPop, memPush, memPop, push, pop;
  logic [DATA_W-1:0] pushData, head;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign head      = slots[rdPtr];

  // buffer role follows the latched direction
  assign hostPop  = !workDirQ && !fifoEmpty && hostRdReady;
  assign hostPush =  workDirQ && !fifoFull && hostWrValid;
  assign memPush  = strobe.done && !workDirQ;
  assign memPop   = strobe.done &&  workDirQ;
  assign push     = hostPush || memPush;
  assign pop      = hostPop  || memPop;
  assign pushData = workDirQ ? hostWrData : memRData;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !strobe.start && wrPtr == PTR_W'(i)) slots[i] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strobe.start) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg   <= '0;
      workAddr <= '0;
      workDirQ <= 1'b0;
    end else begin
      if (regWr && regAddr == REG_SEL_PTR) ptrReg <= regWData[ADDR_W-1:0];
      if (strobe.start) begin
        workAddr <= ptrReg;
        workDirQ <= regWData[CTRL_DIR_BIT];
      end else if (strobe.done) begin
        workAddr <= workAddr + ADDR_W'(1);
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_SEL_PTR) begin
      regRdData = DATA_W'(ptrReg);
    end else begin
      regRdData[CTRL_EN_BIT]   = ctrlEnable;
      regRdData[CTRL_DIR_BIT]  = ctrlDir;
      regRdData[CTRL_BUSY_BIT] = busy;
    end
  end

  assign hostWrReady = workDirQ && !fifoFull;
  assign hostRdValid = !workDirQ && !fifoEmpty;
  assign hostRdData  = head;
  assign memAddr     = workAddr;
  assign memWe       = workDirQ;
  assign memWData    = head;
  assign workDir     = workDirQ;

  // R4: each completion steps the working address by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> (workAddr == $past(workAddr) + ADDR_W'(1)));
  // R6: a returning read word never meets a full buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.done && !workDirQ) |-> !fifoFull);
  // R7: a completing write always has a word to consume
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.done && workDirQ) |-> !fifoEmpty);
  // R3: the visible pointer moves only on a host write
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == REG_SEL_PTR) |=> $stable(ptrReg));
  // R10: direction in force changes only at a start
  a_r10_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.start |=> $stable(workDirQ));

endmodule

// File: rtl/hostDmaEngine.sv
module hostDmaEngine
  import hostDmaPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              hostWrValid,
  output logic              hostWrReady,
  input  logic [DATA_W-1:0] hostWrData,
  output logic              hostRdValid,
  input  logic              hostRdReady,
  output logic [DATA_W-1:0] hostRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRData
);

  engStrobe_t strobe;
  logic ctrlEnable, ctrlDir, busy, fifoEmpty, fifoFull, workDir;

  hostDmaCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .ctrlWData (regWData[1:0]),
    .memAck    (memAck),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .workDir   (workDir),
    .strobe    (strobe),
    .ctrlEnable(ctrlEnable),
    .ctrlDir   (ctrlDir),
    .busy      (busy),
    .memReq    (memReq)
  );

  hostDmaPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (BUF_DEPTH)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWData   (regWData),
    .strobe     (strobe),
    .ctrlEnable (ctrlEnable),
    .ctrlDir    (ctrlDir),
    .busy       (busy),
    .hostWrValid(hostWrValid),
    .hostWrData (hostWrData),
    .hostRdReady(hostRdReady),
    .memRData   (memRData),
    .regRdData  (regRdData),
    .hostWrReady(hostWrReady),
    .hostRdValid(hostRdValid),
    .hostRdData (hostRdData),
    .memAddr    (memAddr),
    .memWe      (memWe),
    .memWData   (memWData),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .workDir    (workDir)
  );

  // R5: request attributes hold until acknowledged
  a_r5_attr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWe)));
  a_r5_wdata_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memAck) |=> $stable(memWData));

endmodule

// File: tb/hostDmaEngine_tb.sv
`timescale 1ns/1ps
module hostDmaEngine_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, regWr, regAddr, hostWrValid, hostRdReady, memAck;
  logic [DW-1:0] regWData, regRdData, hostWrData, hostRdData, memWData, memRData;
  logic hostWrReady, hostRdValid, memReq, memWe;
  logic [AW-1:0] memAddr;

  hostDmaEngine #(.ADDR_W(AW), .DATA_W(DW), .BUF_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .regRdData(regRdData), .hostWrValid(hostWrValid), .hostWrReady(hostWrReady),
    .hostWrData(hostWrData), .hostRdValid(hostRdValid), .hostRdReady(hostRdReady),
    .hostRdData(hostRdData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memAck(memAck), .memRData(memRData)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int wrSeq = 0;
  int ackMode = 0;
  int rdMode = 2;
  int wrMode = 2;
  bit checking = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] mem [256];

  // reference model state
  bit mEn, mDir, mWDir, mInF, mStarted;
  logic [AW-1:0] mPtr, mWA;
  logic [DW-1:0] q [$];
  bit eDone, eIssue, eStart, eCtrlW, eBlock, eRdPop, eWrPush;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 7);
  end

  // memory and host stream responders
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memAck = memReq && (ackMode == 0 ? 1'b1 : ackMode == 1 ? (lfsr[0] | lfsr[3]) : 1'b0);
    memRData = mem[memAddr[7:0]];
    if (memAck && memReq && memWe) mem[memAddr[7:0]] = memWData;
    hostRdReady = (rdMode == 0) ? 1'b1 : (rdMode == 1) ? lfsr[5] : 1'b0;
    hostWrValid = (wrMode == 0) ? 1'b1 : (wrMode == 1) ? (lfsr[7] | lfsr[2]) : 1'b0;
    hostWrData = 16'hA000 + 16'(wrSeq);
  end

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mDir = 0; mWDir = 0; mInF = 0; mStarted = 0;
      mPtr = '0; mWA = '0; q.delete();
    end else begin
      eDone   = mInF && memAck;
      eIssue  = !mInF && mEn && (mWDir ? q.size() > 0 : q.size() < DEPTH);
      eCtrlW  = regWr && (regAddr == 1'b0);
      eBlock  = eCtrlW && !mEn && mInF;
      eStart  = eCtrlW && regWData[0] && !mEn && !mInF;
      eRdPop  = !mWDir && q.size() > 0 && hostRdReady;
      eWrPush = mWDir && q.size() < DEPTH && hostWrValid;
      if (eWrPush) wrSeq++;
      if (eStart) begin
        q.delete(); mWA = mPtr; mWDir = regWData[1]; mStarted = 0;
      end else begin
        if (!mWDir) begin
          if (eRdPop) void'(q.pop_front());
          if (eDone) q.push_back(memRData);
        end else begin
          if (eDone) void'(q.pop_front());
          if (eWrPush) q.push_back(hostWrData);
        end
        if (eDone) mWA = mWA + 1'b1;
      end
      if (eIssue) begin mInF = 1; mStarted = 1; end
      if (eDone) mInF = 0;
      if (eCtrlW && !eBlock) begin mEn = regWData[0]; mDir = regWData[1]; end
      if (regWr && regAddr == 1'b1) mPtr = regWData;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (checking) begin
      check("R5", "memReq", 32'(memReq), 32'(mInF));
      if (mInF) begin
        check("R4", "memAddr", 32'(memAddr), 32'(mWA));
        check("R10", "memWe", 32'(memWe), 32'(mWDir));
        if (mWDir) check("R7", "memWData", 32'(memWData), 32'(q[0]));
      end
      check("R6", "hostRdValid", 32'(hostRdValid), 32'(!mWDir && q.size() > 0));
      if (!mWDir && q.size() > 0) check("R6", "hostRdData", 32'(hostRdData), 32'(q[0]));
      check("R7", "hostWrReady", 32'(hostWrReady), 32'(mWDir && q.size() < DEPTH));
      if (regAddr == 1'b0) begin
        check("R2", "ctrl en/dir", 32'(regRdData[1:0]), 32'({mDir, mEn}));
        check("R9", "busy", 32'(regRdData[2]), 32'(mInF || (mEn && mStarted)));
        check("R2", "ctrl upper", 32'(regRdData[DW-1:3]), 32'(0));
      end else begin
        check("R3", "pointer", 32'(regRdData), 32'(mPtr));
      end
    end
  end

  task automatic writeReg(input logic a, input logic [DW-1:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [DW-1:0] d);
    @(negedge clk); regWr = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(negedge clk); regWr = 1'b0; regAddr = ~regAddr; end
  endtask

  task automatic waitReq(output bit got);
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk); regWr = 1'b0;
      #1 got = memReq;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected<=%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    bit got;
    rstN = 1'b0; regWr = 1'b0; regAddr = 1'b0; regWData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; checking = 1;

    // R1 reset state
    readReg(1'b0, d); check("R1", "ctrl after reset", 32'(d), 32'(0));
    check("R1", "memReq after reset", 32'(memReq), 32'(0));
    check("R1", "hostRdValid after reset", 32'(hostRdValid), 32'(0));
    check("R1", "hostWrReady after reset", 32'(hostWrReady), 32'(0));
    readReg(1'b1, d); check("R1", "pointer after reset", 32'(d), 32'(0));

    // read transfer from 0x0010
    writeReg(1'b1, 16'h0010);
    readReg(1'b1, d); check("R2", "pointer readback", 32'(d), 32'h10);
    rdMode = 1; ackMode = 1;
    writeReg(1'b0, 16'h0001);
    waitReq(got);
    check("R3", "first read address", 32'(memAddr), 32'h10);
    run(40);

    // host stalls: buffer fills, requests stop
    rdMode = 2;
    run(20);
    check("R6", "no request with full buffer", 32'(memReq), 32'(0));
    check("R6", "data waiting", 32'(hostRdValid), 32'(1));
    writeReg(1'b1, 16'h0050);
    readReg(1'b1, d); check("R3", "pointer moved mid-transfer", 32'(d), 32'h50);
    rdMode = 1;
    run(20);

    // clear enable with a cycle held by memory, then attempt restart
    ackMode = 2; rdMode = 0;
    waitReq(got);
    check("R8", "cycle outstanding", 32'(got), 32'(1));
    writeReg(1'b0, 16'h0000);
    writeReg(1'b0, 16'h0001);
    readReg(1'b0, d); check("R8", "restart ignored while draining", 32'(d), 32'h4);
    ackMode = 0;
    run(3);
    check("R8", "last cycle completed", 32'(memReq), 32'(0));
    readReg(1'b0, d); check("R9", "busy low after drain", 32'(d), 32'(0));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1 check("R8", "no request while disabled", 32'(memReq), 32'(0));
    end

    // write transfer from 0x0050
    wrMode = 1; ackMode = 1;
    writeReg(1'b0, 16'h0003);
    waitReq(got);
    check("R3", "first write address", 32'(memAddr), 32'h50);
    check("R10", "write direction", 32'(memWe), 32'(1));
    run(30);
    writeReg(1'b0, 16'h0001);
    readReg(1'b0, d); check("R10", "visible direction bit", 32'(d[1:0]), 32'h1);
    waitReq(got);
    check("R10", "direction held", 32'(memWe), 32'(1));
    run(20);
    writeReg(1'b0, 16'h0000);
    wrMode = 2;
    run(10);
    check("R7", "first word in memory", 32'(mem[8'h50]), 32'hA000);
    check("R7", "second word in memory", 32'(mem[8'h51]), 32'hA001);

    // address wrap from the top of the space
    writeReg(1'b1, 16'hFFFE);
    rdMode = 1; ackMode = 1;
    writeReg(1'b0, 16'h0001);
    got = 0;
    for (int i = 0; i < 80 && !got; i++) begin
      @(negedge clk); #1 got = memReq && (memAddr == 16'h0000);
    end
    check("R4", "address wrapped to zero", 32'(got), 32'(1));
    run(10);
    writeReg(1'b0, 16'h0000);
    run(10);

    checking = 0;
    summary();
    $finish;
  end

endmodule